// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block sequences the lights at a crossing of two roads, called road A and road B. Each road has a sensor input that is high while cars are waiting or passing. The block drives a 2-bit light code per road. A road keeps its green light for as long as its own sensor reports traffic. When that sensor falls, the road shows yellow for exactly one clock cycle, and then the other road turns green.

The controller is a Moore machine with four phases held in a 2-bit register. It has an asynchronous, active-high reset. Both light codes are decoded from the registered phase alone, so the lights change only at a rising clock edge. The phase register is also brought out on a port so it can be observed.

Top module: `crossing_light_ctrl`

## Requirements
- R1: While reset is high, and after it is released, the phase is 00, road A shows green (00) and road B shows red (10).
- R2: In phase 00, a high road A sensor keeps the phase at 00 and a low one moves it to 01 at the next rising edge; the road B sensor has no effect.
- R3: Phase 01 always moves to phase 10 at the next rising edge, whatever the sensor values.
- R4: In phase 10, a high road B sensor keeps the phase at 10 and a low one moves it to 11 at the next rising edge; the road A sensor has no effect.
- R5: Phase 11 always moves to phase 00 at the next rising edge, whatever the sensor values.
- R6: Light codes are green=00, yellow=01, red=10. The lights by phase are: 00 gives A green and B red; 01 gives A yellow and B red; 10 gives A red and B green; 11 gives A red and B yellow.
- R7: The code 11 never appears on either light output.
- R8: In every cycle at least one of the two roads shows red.
- R9: Raising reset forces phase 00 at once, without waiting for a clock edge. Outside reset, the phase and the lights change only at a rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; the phase advances on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset to phase 00 |
| road_a_busy_i | input | 1 | Road A traffic sensor, high when cars are present |
| road_b_busy_i | input | 1 | Road B traffic sensor, high when cars are present |
| light_a_o | output | 2 | Road A light code (00 green, 01 yellow, 10 red) |
| light_b_o | output | 2 | Road B light code (00 green, 01 yellow, 10 red) |
| phase_o | output | 2 | Current phase register value |

## Verification
The phase register drives every output directly through decode logic. A wrong next phase therefore shows up on phase_o and on at least one light code at the very edge where it is taken. Examples are a missed hold, a skipped yellow, or a sensor acting in the wrong phase. A wrong light decode with a correct phase is caught in the same cycle: the lights are compared against the phase table, and the bench also checks that neither code is 11 and that at least one road is red. Random sensor sequences are mixed with long holds, sensors that drop on the first green cycle, and a reset raised mid-cycle. Together these reach every transition, both with and without the input that is meant to be ignored.

// File: rtl/xl_pkg.sv
package xl_pkg;

    localparam int PHASE_W   = 2;
    localparam int LAMP_W    = 2;
    localparam int NUM_ROADS = 2;

    // Phase encoding is visible on phase_o and used by the lamp decoders.
    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_e;

    typedef enum logic [LAMP_W-1:0] {
        LAMP_GREEN  = 2'b00,
        LAMP_YELLOW = 2'b01,
        LAMP_RED    = 2'b10
    } lamp_e;

    typedef struct packed {
        phase_e phase;
    } ctrl_s;

    localparam ctrl_s CTRL_RESET = '{phase: PH_A_GO};

endpackage

// File: rtl/xl_phase_next.sv
module xl_phase_next
    import xl_pkg::*;
(
    input  phase_e phase_i,
    input  logic   a_busy_i,
    input  logic   b_busy_i,
    output phase_e phase_o
);

    always_comb begin
        phase_o = phase_i;
        unique case (phase_i)
            PH_A_GO:   phase_o = a_busy_i ? PH_A_GO : PH_A_WARN;
            PH_A_WARN: phase_o = PH_B_GO;
            PH_B_GO:   phase_o = b_busy_i ? PH_B_GO : PH_B_WARN;
            PH_B_WARN: phase_o = PH_A_GO;
            default:   phase_o = PH_A_GO;
        endcase
    end

endmodule

// File: rtl/xl_lamp_decode.sv
module xl_lamp_decode
    import xl_pkg::*;
#(
    parameter int ROAD = 0
) (
    input  phase_e             phase_i,
    output logic [LAMP_W-1:0]  lamp_o
);

    // Road r owns the phases whose upper bit equals r.
    localparam logic OWN_HI = (ROAD % 2) != 0;
    localparam logic [PHASE_W-1:0] GO_CODE   = {OWN_HI, 1'b0};
    localparam logic [PHASE_W-1:0] WARN_CODE = {OWN_HI, 1'b1};

    lamp_e lamp;

    always_comb begin
        if (phase_i == GO_CODE) begin
            lamp = LAMP_GREEN;
        end else if (phase_i == WARN_CODE) begin
            lamp = LAMP_YELLOW;
        end else begin
            lamp = LAMP_RED;
        end
    end

    assign lamp_o = lamp;

endmodule

// File: rtl/crossing_light_ctrl.sv
module crossing_light_ctrl
    import xl_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               road_a_busy_i,
    input  logic               road_b_busy_i,
    output logic [LAMP_W-1:0]  light_a_o,
    output logic [LAMP_W-1:0]  light_b_o,
    output logic [PHASE_W-1:0] phase_o
);

    ctrl_s  ctrl_d, ctrl_q;
    phase_e phase_nxt;
    logic [LAMP_W-1:0] lamp [NUM_ROADS];

    xl_phase_next u_phase_next (
        .phase_i  (ctrl_q.phase),
        .a_busy_i (road_a_busy_i),
        .b_busy_i (road_b_busy_i),
        .phase_o  (phase_nxt)
    );

    always_comb begin
        ctrl_d       = ctrl_q;
        ctrl_d.phase = phase_nxt;
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    for (genvar r = 0; r < NUM_ROADS; r++) begin : g_road
        xl_lamp_decode #(.ROAD(r)) u_lamp (
            .phase_i (ctrl_q.phase),
            .lamp_o  (lamp[r])
        );
    end

    assign light_a_o = lamp[0];
    assign light_b_o = lamp[1];
    assign phase_o   = ctrl_q.phase;

    AST_A_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b00 && road_a_busy_i) |=> (phase_o == 2'b00)); // R2
    AST_A_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b00 && !road_a_busy_i) |=> (phase_o == 2'b01)); // R2
    AST_A_WARN_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b01) |=> (phase_o == 2'b10)); // R3
    AST_B_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b10 && road_b_busy_i) |=> (phase_o == 2'b10)); // R4
    AST_B_RELEASE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b10 && !road_b_busy_i) |=> (phase_o == 2'b11)); // R4
    AST_B_WARN_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'b11) |=> (phase_o == 2'b00)); // R5
    AST_NO_CODE3: assert property (@(posedge clk_i) disable iff (rst_i)
        (light_a_o != 2'b11) && (light_b_o != 2'b11)); // R7
    AST_ONE_RED: assert property (@(posedge clk_i) disable iff (rst_i)
        (light_a_o == 2'b10) || (light_b_o == 2'b10)); // R8
    AST_GREEN_MATCH: assert property (@(posedge clk_i) disable iff (rst_i)
        (light_a_o == 2'b00) == (phase_o == 2'b00)); // R6

endmodule

// File: tb/test_crossing_light_ctrl.sv
module test_crossing_light_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_busy = 1'b0;
    logic       b_busy = 1'b0;
    logic [1:0] light_a, light_b, phase;

    int checks = 0;
    int fails  = 0;
    logic [1:0] exp_phase = 2'b00;

    always #4 clk = ~clk;

    crossing_light_ctrl i_crossing_light_ctrl (
        .clk_i         (clk),
        .rst_i         (rst),
        .road_a_busy_i (a_busy),
        .road_b_busy_i (b_busy),
        .light_a_o     (light_a),
        .light_b_o     (light_b),
        .phase_o       (phase)
    );

    function automatic logic [1:0] next_of(logic [1:0] p, logic a, logic b);
        case (p)
            2'b00:   return a ? 2'b00 : 2'b01;
            2'b01:   return 2'b10;
            2'b10:   return b ? 2'b10 : 2'b11;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [3:0] lights_of(logic [1:0] p);
        case (p)
            2'b00:   return {2'b00, 2'b10};
            2'b01:   return {2'b01, 2'b10};
            2'b10:   return {2'b10, 2'b00};
            default: return {2'b10, 2'b01};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string req);
        logic [3:0] el;
        el = lights_of(exp_phase);
        chk(phase == exp_phase, req, {2'b00, phase}, {2'b00, exp_phase});
        chk({light_a, light_b} == el, "R6", {light_a, light_b}, el);
        chk(light_a != 2'b11 && light_b != 2'b11, "R7", {light_a, light_b}, el);
        chk(light_a == 2'b10 || light_b == 2'b10, "R8", {light_a, light_b}, el);
    endtask

    // Drive sensors after a falling edge, then check after the next falling edge.
    task automatic step(input logic a, input logic b);
        string req;
        case (exp_phase)
            2'b00:   req = "R2";
            2'b01:   req = "R3";
            2'b10:   req = "R4";
            default: req = "R5";
        endcase
        a_busy = a;
        b_busy = b;
        exp_phase = next_of(exp_phase, a, b);
        @(negedge clk);
        check_outputs(req);
    endtask

    initial begin
        #1600000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        #3;
        exp_phase = 2'b00;
        check_outputs("R1");            // R1 during reset
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_outputs("R1");            // R1 right after release

        // A sensor drops in the first green cycle; B busy ignored in A green
        step(1'b0, 1'b1);
        step(1'b1, 1'b1);               // R3 yellow ignores inputs
        step(1'b1, 1'b0);               // B drops first cycle of B green
        step(1'b1, 1'b1);               // R5 yellow ignores inputs
        // Long A hold while B toggles (R2 ignore)
        for (int i = 0; i < 20; i++) step(1'b1, i[0]);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        // Long B hold while A toggles (R4 ignore)
        for (int i = 0; i < 20; i++) step(i[0], 1'b1);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        // R9: no change between edges while inputs move
        a_busy = 1'b0;
        #1;
        chk(phase == exp_phase, "R9", {2'b00, phase}, {2'b00, exp_phase});
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);

        // Random phase: sensors busy with probability 3/4
        for (int i = 0; i < 600; i++) begin
            step(($urandom % 4) != 0, ($urandom % 4) != 0);
        end

        // R9: asynchronous reset from phase 10, checked before any edge
        while (exp_phase != 2'b10) step(1'b0, 1'b1);
        #1;
        rst = 1'b1;
        #1;
        exp_phase = 2'b00;
        chk(phase == 2'b00, "R9", {2'b00, phase}, 4'b0000);
        check_outputs("R1");
        @(negedge clk);
        rst = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule